// File: doc/BRIEF.md
# Flash Command Interpreter with Block Locking

This block behaves like the command layer of a NOR-style flash device, backed by a small on-chip array of 16-bit words. The words are grouped into equal blocks, and each block has its own lock bit. A controller under test writes command words and data words to a single synchronous port. It reads back whatever the current read mode selects: array contents, the status byte, identifier words or query words. Program and erase operations take a fixed number of cycles. During that time the device reports busy, so a controller's polling loop, its lock handling and its error recovery can all be checked against a deterministic model.

Commands are decoded from the low byte of the written word, and the upper byte is ignored. Some commands take effect at once. Others are setup commands that arm a second write. That second write is either the word to program or a confirm code. When the second write is wrong, or when it targets a locked block, sticky error flags are raised in the status byte. These flags stay set until a clear command is written.

Top module: `flash_cmd_model`

## Requirements
- R1: After reset every word reads 0xFFFF, every block is locked, the read mode is array, and the status byte is 0x80.
- R2: Writing a word whose low byte is 0xFF, 0x70, 0x90 or 0x98 selects, in that order, array, status, identifier or query read mode, whatever the upper byte holds. In status mode rdata is {8'h00, status}, where bit 7 = ready (0 while busy), bit 5 = erase or sequence error, bit 4 = program or sequence error, bit 1 = locked-block error, and every other bit is 0.
- R3: In identifier mode, block offset 0 reads 0x00A5, offset 1 reads 0x1C3E, offset 2 reads that block's lock bit in bit 0, and every other offset reads 0. In query mode, word addresses 0x10, 0x11 and 0x12 read 0x0051, 0x0052 and 0x0059, and every other address reads 0.
- R4: 0x60 followed by 0xD0 clears the lock bit of the block that holds the confirm write's address, and leaves status mode selected.
- R5: 0x40 followed by a data write at address A starts a program. Status reads busy for PROG_CYC cycles, and then word A holds the old value ANDed with the data.
- R6: 0x20 followed by 0xD0 at an address in a block starts an erase. Status reads busy for ERASE_CYC cycles, and then every word of that block holds 0xFFFF.
- R7: A program that targets a locked block sets bits 4 and 1. An erase that targets a locked block sets bits 5 and 1. In both cases the array is left unchanged and no busy period starts.
- R8: 0x20 or 0x60 followed by anything other than 0xD0 sets bits 5 and 4, changes neither the array nor the lock bits, and leaves status mode selected.
- R9: Error bits are sticky across mode changes. Only 0x50 clears them, and 0x50 leaves the read mode unchanged.
- R10: Every write made while busy is ignored, including a write made in the cycle where the operation completes.
- R11: A command code not listed above, or 0xD0 without a setup, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for a command or data word |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Command or data word |
| rdata | output | 16 | Read data for the current mode and address |

## Verification
The collision of interest is the completion of a program or erase and a new write in the same cycle. The bench provokes it by timing a write of 0xFF so that it lands on exactly the clock edge where the busy counter expires. The write must be dropped: the read mode stays on status, and the programmed word shows only the result of the operation. A second case issues an unlock sequence in the middle of an erase, and the block must still read as locked afterwards. A behavioural model, stepped on every clock, judges both cases against rdata.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2,
    MODE_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE        = 2'd0,
    ST_PROG_DATA   = 2'd1,
    ST_ERASE_CONF  = 2'd2,
    ST_UNLOCK_CONF = 2'd3
  } cmd_state_e;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;

  localparam logic [7:0] OPC_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OPC_READ_STATUS = 8'h70;
  localparam logic [7:0] OPC_READ_IDENT  = 8'h90;
  localparam logic [7:0] OPC_READ_QUERY  = 8'h98;
  localparam logic [7:0] OPC_CLR_STATUS  = 8'h50;
  localparam logic [7:0] OPC_PROG_SETUP  = 8'h40;
  localparam logic [7:0] OPC_ERASE_SETUP = 8'h20;
  localparam logic [7:0] OPC_UNLK_SETUP  = 8'h60;
  localparam logic [7:0] OPC_CONFIRM     = 8'hD0;

  localparam logic [15:0] ERASED_WORD = 16'hFFFF;

endpackage

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_cmd_pkg::*;
#(
  parameter int PROG_CYC  = 3,
  parameter int ERASE_CYC = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  op_kind_e kind_i,
  output logic     busy_o,
  output logic     done_o
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYC - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = busy_q | start_i;
  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = (kind_i == OP_ERASE) ? ERASE_LOAD : PROG_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cnt_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/flash_lock_bits.sv
module flash_lock_bits #(
  parameter int NUM_BLK = 4,
  localparam int BLK_W  = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_en_i,
  input  logic [BLK_W-1:0]   clr_blk_i,
  output logic [NUM_BLK-1:0] lock_o
);
  logic [NUM_BLK-1:0] lock_q, lock_d, clr_hit;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign clr_hit[b] = clr_en_i && (clr_blk_i == BLK_W'(b));
  end

  assign lock_d = lock_q & ~clr_hit;
  assign lock_o = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= '1;
    else if (clr_en_i) lock_q <= lock_d;
  end
endmodule

// File: rtl/flash_word_array.sv
module flash_word_array
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BLK_ADDR_W = 4,
  localparam int DEPTH     = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en_i,
  input  logic              erase_en_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic [15:0]       prog_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [15:0]       rd_data_o
);
  logic [15:0]      mem_q [DEPTH];
  logic [DEPTH-1:0] wen;
  logic [15:0]      word_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    assign wen[i] = (prog_en_i && (tgt_addr_i == IDX)) ||
                    (erase_en_i && (tgt_addr_i[ADDR_W-1:BLK_ADDR_W] == IDX[ADDR_W-1:BLK_ADDR_W]));
    assign word_d[i] = erase_en_i ? ERASED_WORD : (mem_q[i] & prog_data_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_WORD;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wen[i]) mem_q[i] <= word_d[i];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BLK_ADDR_W = 4,
  localparam int BLK_W     = ADDR_W - BLK_ADDR_W,
  localparam int NUM_BLK   = 1 << BLK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [15:0]        wdata,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic [NUM_BLK-1:0] lock_i,
  output rd_mode_e           mode_o,
  output logic [7:0]         status_o,
  output logic               start_o,
  output op_kind_e           kind_o,
  output logic [ADDR_W-1:0]  tgt_addr_o,
  output logic [15:0]        prog_data_o,
  output logic               commit_prog_o,
  output logic               commit_erase_o,
  output logic               unlock_en_o,
  output logic [BLK_W-1:0]   unlock_blk_o
);
  cmd_state_e        state_q, state_d;
  rd_mode_e          mode_q, mode_d;
  logic              err_erase_q, err_erase_d;
  logic              err_prog_q, err_prog_d;
  logic              err_lock_q, err_lock_d;
  op_kind_e          kind_q, kind_d;
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  logic [15:0]       data_q, data_d;
  logic              accept;
  logic [7:0]        opc;
  logic [BLK_W-1:0]  blk;
  logic              blk_locked;

  assign accept     = wr_en && !busy_i;
  assign opc        = wdata[7:0];
  assign blk        = addr[ADDR_W-1:BLK_ADDR_W];
  assign blk_locked = lock_i[blk];

  always_comb begin
    state_d     = state_q;
    mode_d      = mode_q;
    err_erase_d = err_erase_q;
    err_prog_d  = err_prog_q;
    err_lock_d  = err_lock_q;
    kind_d      = kind_q;
    tgt_d       = tgt_q;
    data_d      = data_q;
    start_o     = 1'b0;
    unlock_en_o = 1'b0;
    if (accept) begin
      unique case (state_q)
        ST_IDLE: begin
          unique case (opc)
            OPC_READ_ARRAY:  mode_d = MODE_ARRAY;
            OPC_READ_STATUS: mode_d = MODE_STATUS;
            OPC_READ_IDENT:  mode_d = MODE_IDENT;
            OPC_READ_QUERY:  mode_d = MODE_QUERY;
            OPC_CLR_STATUS: begin
              err_erase_d = 1'b0;
              err_prog_d  = 1'b0;
              err_lock_d  = 1'b0;
            end
            OPC_PROG_SETUP: begin
              state_d = ST_PROG_DATA;
              mode_d  = MODE_STATUS;
            end
            OPC_ERASE_SETUP: begin
              state_d = ST_ERASE_CONF;
              mode_d  = MODE_STATUS;
            end
            OPC_UNLK_SETUP: begin
              state_d = ST_UNLOCK_CONF;
              mode_d  = MODE_STATUS;
            end
            default: ;
          endcase
        end
        ST_PROG_DATA: begin
          state_d = ST_IDLE;
          if (blk_locked) begin
            err_prog_d = 1'b1;
            err_lock_d = 1'b1;
          end else begin
            start_o = 1'b1;
            kind_d  = OP_PROGRAM;
            tgt_d   = addr;
            data_d  = wdata;
          end
        end
        ST_ERASE_CONF: begin
          state_d = ST_IDLE;
          if (opc != OPC_CONFIRM) begin
            err_erase_d = 1'b1;
            err_prog_d  = 1'b1;
          end else if (blk_locked) begin
            err_erase_d = 1'b1;
            err_lock_d  = 1'b1;
          end else begin
            start_o = 1'b1;
            kind_d  = OP_ERASE;
            tgt_d   = addr;
          end
        end
        ST_UNLOCK_CONF: begin
          state_d = ST_IDLE;
          if (opc == OPC_CONFIRM) begin
            unlock_en_o = 1'b1;
          end else begin
            err_erase_d = 1'b1;
            err_prog_d  = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_ARRAY;
      err_erase_q <= 1'b0;
      err_prog_q  <= 1'b0;
      err_lock_q  <= 1'b0;
      kind_q      <= OP_PROGRAM;
      tgt_q       <= '0;
      data_q      <= '0;
    end else if (accept) begin
      state_q     <= state_d;
      mode_q      <= mode_d;
      err_erase_q <= err_erase_d;
      err_prog_q  <= err_prog_d;
      err_lock_q  <= err_lock_d;
      kind_q      <= kind_d;
      tgt_q       <= tgt_d;
      data_q      <= data_d;
    end
  end

  assign mode_o         = mode_q;
  assign status_o       = {!busy_i, 1'b0, err_erase_q, err_prog_q, 2'b00, err_lock_q, 1'b0};
  assign kind_o         = kind_d;
  assign tgt_addr_o     = tgt_q;
  assign prog_data_o    = data_q;
  assign commit_prog_o  = done_i && (kind_q == OP_PROGRAM);
  assign commit_erase_o = done_i && (kind_q == OP_ERASE);
  assign unlock_blk_o   = blk;
endmodule

// File: rtl/flash_cmd_model.sv
module flash_cmd_model
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W           = 6,
  parameter int BLK_ADDR_W       = 4,
  parameter int PROG_CYC         = 3,
  parameter int ERASE_CYC        = 6,
  parameter logic [15:0] MFR_ID  = 16'h00A5,
  parameter logic [15:0] DEV_ID  = 16'h1C3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata
);
  localparam int BLK_W   = ADDR_W - BLK_ADDR_W;
  localparam int NUM_BLK = 1 << BLK_W;

  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  logic               op_busy, op_done, op_start;
  op_kind_e           op_kind;
  rd_mode_e           rd_mode;
  logic [7:0]         status_q;
  logic [ADDR_W-1:0]  tgt_addr;
  logic [15:0]        prog_data;
  logic               commit_prog, commit_erase;
  logic               unlock_en;
  logic [BLK_W-1:0]   unlock_blk;
  logic [NUM_BLK-1:0] lock_q;
  logic [15:0]        array_word;
  logic [15:0]        ident_word, query_word;
  logic [BLK_ADDR_W-1:0] blk_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  flash_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .start_i(op_start), .kind_i(op_kind),
    .busy_o(op_busy), .done_o(op_done)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .BLK_ADDR_W(BLK_ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy_i(op_busy), .done_i(op_done), .lock_i(lock_q),
    .mode_o(rd_mode), .status_o(status_q), .start_o(op_start), .kind_o(op_kind),
    .tgt_addr_o(tgt_addr), .prog_data_o(prog_data),
    .commit_prog_o(commit_prog), .commit_erase_o(commit_erase),
    .unlock_en_o(unlock_en), .unlock_blk_o(unlock_blk)
  );

  flash_lock_bits #(.NUM_BLK(NUM_BLK)) u_locks (
    .clk(clk), .rst_n(rst_sync_n), .clr_en_i(unlock_en), .clr_blk_i(unlock_blk),
    .lock_o(lock_q)
  );

  flash_word_array #(.ADDR_W(ADDR_W), .BLK_ADDR_W(BLK_ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_sync_n), .prog_en_i(commit_prog), .erase_en_i(commit_erase),
    .tgt_addr_i(tgt_addr), .prog_data_i(prog_data), .rd_addr_i(addr),
    .rd_data_o(array_word)
  );

  assign blk_off = addr[BLK_ADDR_W-1:0];

  always_comb begin
    unique case (blk_off)
      BLK_ADDR_W'(0): ident_word = MFR_ID;
      BLK_ADDR_W'(1): ident_word = DEV_ID;
      BLK_ADDR_W'(2): ident_word = {15'd0, lock_q[addr[ADDR_W-1:BLK_ADDR_W]]};
      default:        ident_word = 16'h0000;
    endcase
  end

  always_comb begin
    unique case (32'(addr))
      32'h10:  query_word = 16'h0051;
      32'h11:  query_word = 16'h0052;
      32'h12:  query_word = 16'h0059;
      default: query_word = 16'h0000;
    endcase
  end

  always_comb begin
    unique case (rd_mode)
      MODE_ARRAY:  rdata = array_word;
      MODE_STATUS: rdata = {8'h00, status_q};
      MODE_IDENT:  rdata = ident_word;
      MODE_QUERY:  rdata = query_word;
      default:     rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BLK = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [15:0]        wdata,
  input logic               busy,
  input rd_mode_e           mode,
  input logic [7:0]         status,
  input logic [NUM_BLK-1:0] lock_q
);
  // R5: an operation only begins after an accepted write
  a_r5_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  // R5: status mode is selected for the whole busy period
  a_r5_busy_status_mode: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode == MODE_STATUS));

  // R10: lock bits cannot move while an operation runs
  a_r10_lock_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(lock_q));

  // R4: lock bits are only ever cleared, never set, outside reset
  a_r4_lock_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & ~$past(lock_q)) == '0);

  // R9: the program-error flag drops only after a clear command
  a_r9_prog_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[4]) |-> $past(wr_en && !busy && (wdata[7:0] == 8'h50)));

  // R9: the erase-error flag drops only after a clear command
  a_r9_erase_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[5]) |-> $past(wr_en && !busy && (wdata[7:0] == 8'h50)));
endmodule

bind flash_cmd_model flash_cmd_checker #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wdata(wdata), .busy(op_busy),
  .mode(rd_mode), .status(status_q), .lock_q(lock_q)
);

// File: tb/tb_flash_cmd_model.sv
module tb_flash_cmd_model;
  localparam int ADDR_W     = 6;
  localparam int BLK_ADDR_W = 4;
  localparam int PROG_CYC   = 3;
  localparam int ERASE_CYC  = 6;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int BLK_WORDS  = 1 << BLK_ADDR_W;
  localparam int NBLK       = DEPTH / BLK_WORDS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       wdata = '0;
  logic [15:0]       rdata;

  int    n_run = 0, n_fail = 0;
  string phase = "R1";
  bit    cmp_on = 1'b0;
  bit    finished = 1'b0;

  always #10 clk = ~clk;

  flash_cmd_model #(.ADDR_W(ADDR_W), .BLK_ADDR_W(BLK_ADDR_W),
                    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  // behavioural reference
  int m_mem [DEPTH];
  bit m_lock [NBLK];
  int m_mode;   // 0 array, 1 status, 2 ident, 3 query
  int m_st;     // 0 idle, 1 await data, 2 await erase confirm, 3 await unlock confirm
  int m_busy, m_kind, m_tgt, m_data;
  bit m_eer, m_epg, m_elk;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
      foreach (m_lock[i]) m_lock[i] = 1'b1;
      m_mode = 0; m_st = 0; m_busy = 0; m_kind = 0; m_tgt = 0; m_data = 0;
      m_eer = 0; m_epg = 0; m_elk = 0;
    end else if (m_busy > 0) begin
      m_busy--;
      if (m_busy == 0) begin
        if (m_kind == 0) m_mem[m_tgt] = m_mem[m_tgt] & m_data;
        else for (int j = 0; j < BLK_WORDS; j++)
          m_mem[(m_tgt / BLK_WORDS) * BLK_WORDS + j] = 16'hFFFF;
      end
    end else if (wr_en) begin
      int c, b;
      c = wdata & 8'hFF;
      b = addr / BLK_WORDS;
      case (m_st)
        0: case (c)
          'hFF: m_mode = 0;
          'h70: m_mode = 1;
          'h90: m_mode = 2;
          'h98: m_mode = 3;
          'h50: begin m_eer = 0; m_epg = 0; m_elk = 0; end
          'h40: begin m_st = 1; m_mode = 1; end
          'h20: begin m_st = 2; m_mode = 1; end
          'h60: begin m_st = 3; m_mode = 1; end
          default: ;
        endcase
        1: begin
          m_st = 0;
          if (m_lock[b]) begin m_epg = 1; m_elk = 1; end
          else begin m_busy = PROG_CYC; m_kind = 0; m_tgt = addr; m_data = wdata; end
        end
        2: begin
          m_st = 0;
          if (c != 'hD0) begin m_eer = 1; m_epg = 1; end
          else if (m_lock[b]) begin m_eer = 1; m_elk = 1; end
          else begin m_busy = ERASE_CYC; m_kind = 1; m_tgt = addr; end
        end
        default: begin
          m_st = 0;
          if (c == 'hD0) m_lock[b] = 1'b0;
          else begin m_eer = 1; m_epg = 1; end
        end
      endcase
    end
  end

  function automatic logic [15:0] model_rdata(input int a);
    int sts;
    sts = ((m_busy == 0) ? 128 : 0) | (m_eer << 5) | (m_epg << 4) | (m_elk << 1);
    case (m_mode)
      0: return 16'(m_mem[a]);
      1: return 16'(sts);
      2: case (a % BLK_WORDS)
           0: return 16'h00A5;
           1: return 16'h1C3E;
           2: return 16'(m_lock[a / BLK_WORDS]);
           default: return 16'h0000;
         endcase
      default: case (a)
           'h10: return 16'h0051;
           'h11: return 16'h0052;
           'h12: return 16'h0059;
           default: return 16'h0000;
         endcase
    endcase
  endfunction

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      logic [15:0] e;
      e = model_rdata(int'(addr));
      n_run++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s per-cycle compare: actual %h expected %h (addr %0d)", phase, rdata, e, addr);
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s directed: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input bit w, input int a, input logic [15:0] d);
    @(posedge clk); #2;
    wr_en = w; addr = ADDR_W'(a); wdata = d;
  endtask

  task automatic cmd(input int a, input logic [15:0] d);
    drive(1'b1, a, d);
  endtask

  task automatic rd(input int a, input logic [15:0] exp, input string tag);
    drive(1'b0, a, 16'h0000);
    @(negedge clk);
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cmp_on = 1'b1;

    // R1: reset state
    phase = "R1";
    rd(0, 16'hFFFF, "R1");
    rd(37, 16'hFFFF, "R1");
    cmd(0, 16'h0070); rd(0, 16'h0080, "R1");
    cmd(0, 16'h0090); rd(18, 16'h0001, "R1");

    // R3: identifier and query words
    phase = "R3";
    rd(0, 16'h00A5, "R3");
    rd(1, 16'h1C3E, "R3");
    rd(5, 16'h0000, "R3");
    cmd(0, 16'h0098);
    rd(16, 16'h0051, "R3");
    rd(17, 16'h0052, "R3");
    rd(18, 16'h0059, "R3");
    rd(19, 16'h0000, "R3");

    // R2: mode selection, upper byte ignored
    phase = "R2";
    cmd(0, 16'h00FF); rd(4, 16'hFFFF, "R2");
    cmd(0, 16'h0070); rd(4, 16'h0080, "R2");
    cmd(0, 16'hAB90); rd(1, 16'h1C3E, "R2");

    // R7: locked program and locked erase
    phase = "R7";
    cmd(0, 16'h00FF);
    cmd(3, 16'h0040); cmd(3, 16'h1234);
    rd(3, 16'h0092, "R7");
    cmd(0, 16'h0050); rd(0, 16'h0080, "R9");
    cmd(0, 16'h00FF); rd(3, 16'hFFFF, "R7");
    cmd(40, 16'h0020); cmd(40, 16'h00D0);
    rd(40, 16'h00A2, "R7");
    cmd(0, 16'h0050); rd(0, 16'h0080, "R9");

    // R8 / R9: sequence errors, stickiness
    phase = "R8";
    cmd(0, 16'h0020); cmd(0, 16'h00FF);
    rd(0, 16'h00B0, "R8");
    phase = "R9";
    cmd(0, 16'h0090); cmd(0, 16'h0070);
    rd(0, 16'h00B0, "R9");
    cmd(0, 16'h00FF); rd(0, 16'hFFFF, "R8");
    phase = "R8";
    cmd(0, 16'h0060); cmd(0, 16'h0070);
    rd(0, 16'h00B0, "R8");
    cmd(0, 16'h0090); rd(2, 16'h0001, "R8");
    cmd(0, 16'h0050); rd(2, 16'h0001, "R9");

    // R11: unknown codes and a lone confirm
    phase = "R11";
    cmd(0, 16'h00FF); cmd(0, 16'h0012);
    rd(2, 16'hFFFF, "R11");
    cmd(0, 16'h00D0); rd(2, 16'hFFFF, "R11");

    // R4: unlock block 0
    phase = "R4";
    cmd(0, 16'h0060); cmd(5, 16'h00D0);
    rd(0, 16'h0080, "R4");
    cmd(0, 16'h0090);
    rd(2, 16'h0000, "R4");
    rd(18, 16'h0001, "R4");

    // R5: program with busy window
    phase = "R5";
    cmd(0, 16'h00FF);
    cmd(3, 16'h0040); cmd(3, 16'h1234);
    rd(3, 16'h0000, "R5");
    rd(3, 16'h0000, "R5");
    rd(3, 16'h0000, "R5");
    rd(3, 16'h0080, "R5");
    cmd(0, 16'h00FF); rd(3, 16'h1234, "R5");
    cmd(3, 16'h0040); cmd(3, 16'hFF0F);
    repeat (PROG_CYC) drive(1'b0, 3, 16'h0000);
    cmd(0, 16'h00FF); rd(3, 16'h1204, "R5");

    // R10: write landing on the completion edge is dropped
    phase = "R10";
    cmd(3, 16'h0040); cmd(3, 16'h0F0F);
    drive(1'b0, 3, 16'h0000);
    drive(1'b0, 3, 16'h0000);
    cmd(0, 16'h00FF);
    rd(3, 16'h0080, "R10");
    cmd(0, 16'h00FF); rd(3, 16'h0204, "R10");

    // R6 with R10: erase block 0, unlock attempt mid-erase ignored
    phase = "R6";
    cmd(5, 16'h0020); cmd(5, 16'h00D0);
    cmd(16, 16'h0060); cmd(16, 16'h00D0);
    repeat (5) drive(1'b0, 0, 16'h0000);
    cmd(0, 16'h0090);
    rd(18, 16'h0001, "R10");
    cmd(0, 16'h00FF);
    rd(3, 16'hFFFF, "R6");
    rd(15, 16'hFFFF, "R6");
    rd(16, 16'hFFFF, "R6");

    drive(1'b0, 0, 16'h0000);
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule